// File: doc/BRIEF.md
# Serial Mouse Port Responder

This block plays the device side of a mouse plugged into a game-controller port that uses a latch line, a clock line and one data line. The host raises the latch, lowers it, and then pulses the clock; the block answers with a 32-bit frame on the data line. Logical ones are driven low. The first 16 bits have the layout of an ordinary pad frame: two button bits, a sensitivity field and an identity bit. The last 16 bits carry, for each axis, a direction bit and a 7-bit magnitude.

Motion arrives as signed increments on a valid strobe and is summed per axis between polls. A poll takes a snapshot of the sums and clears them. The latch is sampled against the system clock, and its width decides what a pulse means. A long pulse is a poll. A short pulse is counted toward a burst, and a complete burst steps the mouse through its three sensitivity modes. The port lines are assumed to be synchronous to `clk` already.

Top module: `mouse_port_responder`

## Requirements
- R1: After reset the data line is low. The sensitivity mode is low, both motion sums are zero, and both direction bits are logical 0.
- R2: A latch pulse that stays high for at least SHORT_LIMIT system clocks is a poll. On the clock after the latch falls, bit 1 appears on the data line. Each falling edge of the port clock while the latch is low moves the frame on by one bit. Falling clock edges while the latch is high have no effect.
- R3: Frame bits 1–8 and 13–15 are driven high. Bit 9 is driven low when the left button is pressed and bit 10 when the right button is pressed. Bit 16 is always driven low (identity).
- R4: Bits 11 and 12 give the mode as line levels. Low mode is high/high, medium is high/low, and high is low/high. The mode is captured at the poll.
- R5: Bit 17 is the Y direction as a logical value, where 1 means down (a positive increment). Bits 18 to 24 are Y magnitude bits 6 down to 0. Every logical bit is driven inverted.
- R6: Bit 25 is the X direction as a logical value, where 1 means right (a positive increment). Bits 26 to 32 are X magnitude bits 6 down to 0, driven inverted.
- R7: Each poll reports the sum of the increments received since the previous poll, then clears the sum. An increment that arrives in the cycle of the poll counts toward the next poll.
- R8: Each signed sum saturates at +127 and -127, so a reported magnitude never exceeds 127.
- R9: When an axis sum is zero at a poll, its magnitude bits read high and its direction bit keeps the value it had at the previous poll.
- R10: Once all 32 bits have been clocked out, and from reset until the first poll, the data line is low.
- R11: A poll followed by at least 16 clock falls arms a burst. Once a burst is armed, BURST_LEN (31) short pulses step the mode low→medium→high→low, and the new mode appears at the next poll. Fewer pulses, or pulses sent before the burst is armed, leave the mode unchanged. A poll restarts the count.
- R12: A short latch pulse (fewer than SHORT_LIMIT clocks) is not a poll. It leaves the bit position and the motion sums unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_latch | input | 1 | Host latch line, high = latching |
| port_clk | input | 1 | Host shift clock, idle high |
| btn_left | input | 1 | Left button, high = pressed |
| btn_right | input | 1 | Right button, high = pressed |
| mot_valid | input | 1 | Motion increment strobe |
| mot_dx | input | INC_W | Signed X increment, positive = right |
| mot_dy | input | INC_W | Signed Y increment, positive = down |
| port_data | output | 1 | Serial data, active low |

## Verification
Bit-position state shows up at once. A pointer that moves on a latch-high clock edge, or that rewinds on a short pulse, shifts every later bit of the same read, so the first mismatch appears within one bit time. Accumulator and direction faults stay hidden until the next poll, where they corrupt bits 17–32 of that frame. A fault in the burst counter or the mode register only shows in bits 11 and 12 of the poll after a burst. For that reason the bench polls straight after each burst, and also after a burst one pulse short.

// File: rtl/mouse_pkg.sv
package mouse_pkg;

  localparam int FRAME_BITS = 32;
  localparam int MAG_BITS   = 7;
  localparam int HALF_BITS  = 16;

  // zero-based frame positions the host decodes
  localparam int POS_LEFT  = 8;
  localparam int POS_RIGHT = 9;
  localparam int POS_SENS1 = 10;
  localparam int POS_SENS2 = 11;
  localparam int POS_ID    = 15;
  localparam int POS_YDIR  = 16;
  localparam int POS_XDIR  = 24;

  typedef enum logic [1:0] {
    SENS_LOW  = 2'd0,
    SENS_MED  = 2'd1,
    SENS_HIGH = 2'd2
  } sens_e;

  function automatic sens_e sens_next(sens_e s);
    case (s)
      SENS_LOW:  return SENS_MED;
      SENS_MED:  return SENS_HIGH;
      default:   return SENS_LOW;
    endcase
  endfunction

  // line levels {first field bit, second field bit}
  function automatic logic [1:0] sens_lines(sens_e s);
    case (s)
      SENS_MED:  return 2'b10;
      SENS_HIGH: return 2'b01;
      default:   return 2'b11;
    endcase
  endfunction

  function automatic int clamp_add(int a, int b, int lim);
    int s;
    s = a + b;
    if (s > lim)  return lim;
    if (s < -lim) return -lim;
    return s;
  endfunction

  // line-level frame, index 0 is the bit shown right after the poll
  function automatic logic [FRAME_BITS-1:0] frame_lines(
    logic left, logic right, sens_e s,
    logic ydir, logic [MAG_BITS-1:0] ymag,
    logic xdir, logic [MAG_BITS-1:0] xmag);
    logic [FRAME_BITS-1:0] lg;
    logic [1:0] sl;
    lg = '0;
    sl = sens_lines(s);
    lg[POS_LEFT]  = left;
    lg[POS_RIGHT] = right;
    lg[POS_SENS1] = ~sl[1];
    lg[POS_SENS2] = ~sl[0];
    lg[POS_ID]    = 1'b1;
    lg[POS_YDIR]  = ydir;
    lg[POS_XDIR]  = xdir;
    for (int i = 0; i < MAG_BITS; i++) begin
      lg[POS_YDIR+1+i] = ymag[MAG_BITS-1-i];
      lg[POS_XDIR+1+i] = xmag[MAG_BITS-1-i];
    end
    return ~lg;
  endfunction

endpackage

// File: rtl/port_event_decoder.sv
module port_event_decoder #(
  parameter int SHORT_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic port_latch,
  input  logic port_clk,
  output logic poll_evt,
  output logic short_evt,
  output logic clk_fall_evt
);
  localparam int WID_W = $clog2(SHORT_LIMIT + 1);

  logic             latch_q;
  logic             pclk_q;
  logic [WID_W-1:0] width_q;
  logic             latch_fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      pclk_q  <= 1'b1;
      width_q <= '0;
    end else begin
      latch_q <= port_latch;
      pclk_q  <= port_clk;
      if (!port_latch)
        width_q <= '0;
      else if (width_q != WID_W'(SHORT_LIMIT))
        width_q <= width_q + 1'b1;
    end
  end

  assign latch_fall   = latch_q & ~port_latch;
  assign poll_evt     = latch_fall & (width_q >= WID_W'(SHORT_LIMIT));
  assign short_evt    = latch_fall & (width_q <  WID_W'(SHORT_LIMIT));
  assign clk_fall_evt = pclk_q & ~port_clk & ~port_latch;

endmodule

// File: rtl/motion_axis.sv
module motion_axis
  import mouse_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inc_valid,
  input  logic signed [INC_W-1:0] inc,
  input  logic                    poll,
  output logic                    snap_dir,
  output logic [MAG_BITS-1:0]     snap_mag
);
  localparam int LIM   = (1 << MAG_BITS) - 1;
  localparam int ACC_W = MAG_BITS + 1;

  logic signed [ACC_W-1:0] acc_q;
  logic                    dir_q;
  int                      acc_i;
  int                      inc_i;
  int                      mag_i;

  always_comb begin
    acc_i    = int'(acc_q);
    inc_i    = inc_valid ? int'(inc) : 0;
    mag_i    = (acc_i < 0) ? -acc_i : acc_i;
    snap_mag = MAG_BITS'(mag_i);
    if (acc_i > 0)      snap_dir = 1'b1;
    else if (acc_i < 0) snap_dir = 1'b0;
    else                snap_dir = dir_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      dir_q <= 1'b0;
    end else if (poll) begin
      acc_q <= ACC_W'(clamp_add(0, inc_i, LIM));
      dir_q <= snap_dir;
    end else begin
      acc_q <= ACC_W'(clamp_add(acc_i, inc_i, LIM));
    end
  end

endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import mouse_pkg::*;
#(
  parameter int PTR_W = $clog2(FRAME_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] load_word,
  input  logic                  advance,
  output logic [PTR_W-1:0]      bit_ptr,
  output logic                  line_out
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [PTR_W-1:0]      ptr_q;
  logic                  in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q <= '0;
      ptr_q   <= PTR_W'(FRAME_BITS);
    end else if (load) begin
      frame_q <= load_word;
      ptr_q   <= '0;
    end else if (advance && in_frame) begin
      ptr_q   <= ptr_q + 1'b1;
    end
  end

  assign in_frame = (ptr_q < PTR_W'(FRAME_BITS));
  assign bit_ptr  = ptr_q;
  assign line_out = in_frame ? frame_q[ptr_q[IDX_W-1:0]] : 1'b0;

endmodule

// File: rtl/sens_rotator.sv
module sens_rotator
  import mouse_pkg::*;
#(
  parameter int BURST_LEN = 31,
  parameter int CNT_W     = $clog2(BURST_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll,
  input  logic             short_pulse,
  input  logic             half_read,
  output sens_e            sens,
  output logic             advance,
  output logic [CNT_W-1:0] burst_cnt
);
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  sens_e            sens_q;
  logic             counting;

  assign counting  = short_pulse & armed_q & half_read;
  assign advance   = counting & (cnt_q == CNT_W'(BURST_LEN - 1));
  assign sens      = sens_q;
  assign burst_cnt = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sens_q  <= SENS_LOW;
    end else if (poll) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (advance) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      sens_q  <= sens_next(sens_q);
    end else if (counting) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/mouse_port_responder.sv
module mouse_port_responder
  import mouse_pkg::*;
#(
  parameter int SHORT_LIMIT = 8,
  parameter int BURST_LEN   = 31,
  parameter int INC_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_latch,
  input  logic             port_clk,
  input  logic             btn_left,
  input  logic             btn_right,
  input  logic             mot_valid,
  input  logic [INC_W-1:0] mot_dx,
  input  logic [INC_W-1:0] mot_dy,
  output logic             port_data
);
  localparam int AXES  = 2;
  localparam int PTR_W = $clog2(FRAME_BITS + 1);
  localparam int CNT_W = $clog2(BURST_LEN + 1);

  // named internal events for the checker
  logic                  poll_evt;
  logic                  short_evt;
  logic                  clk_fall_evt;
  logic                  sens_adv_evt;
  logic                  half_read;
  logic [PTR_W-1:0]      bit_ptr;
  logic [CNT_W-1:0]      burst_cnt;
  sens_e                 sens_q;
  logic [FRAME_BITS-1:0] frame_word;

  logic signed [INC_W-1:0]    axis_inc [AXES];
  logic                       axis_dir [AXES];
  logic [MAG_BITS-1:0]        axis_mag [AXES];

  assign axis_inc[0] = mot_dx;
  assign axis_inc[1] = mot_dy;

  port_event_decoder #(.SHORT_LIMIT(SHORT_LIMIT)) u_events (
    .clk          (clk),
    .rst_n        (rst_n),
    .port_latch   (port_latch),
    .port_clk     (port_clk),
    .poll_evt     (poll_evt),
    .short_evt    (short_evt),
    .clk_fall_evt (clk_fall_evt)
  );

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    motion_axis #(.INC_W(INC_W)) u_axis (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc_valid (mot_valid),
      .inc       (axis_inc[a]),
      .poll      (poll_evt),
      .snap_dir  (axis_dir[a]),
      .snap_mag  (axis_mag[a])
    );
  end

  assign frame_word = frame_lines(btn_left, btn_right, sens_q,
                                  axis_dir[1], axis_mag[1],
                                  axis_dir[0], axis_mag[0]);

  frame_shifter #(.PTR_W(PTR_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (poll_evt),
    .load_word (frame_word),
    .advance   (clk_fall_evt),
    .bit_ptr   (bit_ptr),
    .line_out  (port_data)
  );

  assign half_read = (bit_ptr >= PTR_W'(HALF_BITS));

  sens_rotator #(.BURST_LEN(BURST_LEN), .CNT_W(CNT_W)) u_sens (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll        (poll_evt),
    .short_pulse (short_evt),
    .half_read   (half_read),
    .sens        (sens_q),
    .advance     (sens_adv_evt),
    .burst_cnt   (burst_cnt)
  );

endmodule

// File: rtl/mouse_port_responder_chk.sv
module mouse_port_responder_chk
  import mouse_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int CNT_W = 5,
  parameter int BURST_LEN = 31
) (
  input logic             clk,
  input logic             rst_n,
  input logic             poll_evt,
  input logic             short_evt,
  input logic             clk_fall_evt,
  input logic             sens_adv_evt,
  input logic [1:0]       sens_q,
  input logic [PTR_W-1:0] bit_ptr,
  input logic [CNT_W-1:0] burst_cnt,
  input logic             port_data
);

  // R11
  sens_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sens_q != 2'd3);

  // R11
  sens_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sens_adv_evt |=> sens_q == 2'(sens_next(sens_e'($past(sens_q)))));

  // R11
  sens_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sens_adv_evt |=> $stable(sens_q));

  // R11
  burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_cnt < CNT_W'(BURST_LEN));

  // R2
  poll_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_evt |=> bit_ptr == '0);

  // R2
  ptr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!poll_evt && !clk_fall_evt) |=> $stable(bit_ptr));

  // R12
  short_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    short_evt |=> $stable(bit_ptr));

  // R10
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ptr >= PTR_W'(FRAME_BITS) |-> !port_data);

  // R3
  ident_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ptr == PTR_W'(POS_ID) |-> !port_data);

endmodule

bind mouse_port_responder mouse_port_responder_chk #(
  .PTR_W(PTR_W), .CNT_W(CNT_W), .BURST_LEN(BURST_LEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .poll_evt     (poll_evt),
  .short_evt    (short_evt),
  .clk_fall_evt (clk_fall_evt),
  .sens_adv_evt (sens_adv_evt),
  .sens_q       (sens_q),
  .bit_ptr      (bit_ptr),
  .burst_cnt    (burst_cnt),
  .port_data    (port_data)
);

// File: tb/mouse_port_responder_bench.sv
module mouse_port_responder_bench;
  localparam int CLK_P    = 10;
  localparam int NORMAL_W = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       port_latch = 1'b0;
  logic       port_clk = 1'b1;
  logic       btn_left = 1'b0;
  logic       btn_right = 1'b0;
  logic       mot_valid = 1'b0;
  logic [7:0] mot_dx = '0;
  logic [7:0] mot_dy = '0;
  logic       port_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mouse_port_responder u_mouse_port_responder (
    .clk(clk), .rst_n(rst_n), .port_latch(port_latch), .port_clk(port_clk),
    .btn_left(btn_left), .btn_right(btn_right), .mot_valid(mot_valid),
    .mot_dx(mot_dx), .mot_dy(mot_dy), .port_data(port_data)
  );

  typedef struct { logic val; int pos; string tag; } exp_t;
  exp_t sb[$];

  // bench-side model
  int ax = 0, ay = 0;
  bit xd = 0, yd = 0;
  int mode = 0;          // 0 low, 1 medium, 2 high
  bit armed = 0;
  int shorts = 0;
  int reads = 0;
  logic [31:0] want;     // want[k] = line level of bit k+1

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    exp_t e;
    @(negedge clk); #1;
    while (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (port_data !== e.val) begin
        failures++;
        $display("FAIL %s bit %0d actual %b expected %b", e.tag, e.pos, port_data, e.val);
      end
    end
  end

  function automatic int sat(int v);
    if (v > 127) return 127;
    if (v < -127) return -127;
    return v;
  endfunction

  function automatic int mag(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic logic [31:0] build(bit l, bit r, int m, bit ydir, int ym,
                                        bit xdir, int xm);
    logic [31:0] v;
    v = '1;
    if (l) v[8] = 1'b0;
    if (r) v[9] = 1'b0;
    if (m == 1) v[11] = 1'b0;
    if (m == 2) v[10] = 1'b0;
    v[15] = 1'b0;
    v[16] = ~ydir;
    v[24] = ~xdir;
    for (int i = 0; i < 7; i++) begin
      v[17+i] = ~ym[6-i];
      v[25+i] = ~xm[6-i];
    end
    return v;
  endfunction

  function automatic string tag_for(int k, string ctx);
    string base;
    if (k == 10 || k == 11) base = "R4";
    else if (k < 16) base = "R3";
    else if (k < 24) base = "R5";
    else base = "R6";
    return $sformatf("%s/%s", base, ctx);
  endfunction

  task automatic expect_line(logic v, int pos, string tag);
    exp_t e;
    e.val = v; e.pos = pos; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic move(int dx, int dy);
    mot_valid = 1'b1; mot_dx = 8'(dx); mot_dy = 8'(dy);
    tick();
    mot_valid = 1'b0;
    ax = sat(ax + dx); ay = sat(ay + dy);
  endtask

  task automatic model_poll(int ndx, int ndy);
    if (ax > 0) xd = 1; else if (ax < 0) xd = 0;
    if (ay > 0) yd = 1; else if (ay < 0) yd = 0;
    want = build(btn_left, btn_right, mode, yd, mag(ay), xd, mag(ax));
    ax = sat(ndx); ay = sat(ndy);
    armed = 1; shorts = 0; reads = 0;
  endtask

  task automatic poll(int ndx = 0, int ndy = 0);
    port_latch = 1'b1;
    repeat (NORMAL_W) tick();
    port_latch = 1'b0;
    if (ndx != 0 || ndy != 0) begin
      mot_valid = 1'b1; mot_dx = 8'(ndx); mot_dy = 8'(ndy);
    end
    tick();
    mot_valid = 1'b0;
    model_poll(ndx, ndy);
  endtask

  // R2: a clock fall while the latch is high must not advance the frame
  task automatic poll_with_clock_inside();
    port_latch = 1'b1;
    tick();
    port_clk = 1'b0;
    tick();
    port_clk = 1'b1;
    repeat (NORMAL_W) tick();
    port_latch = 1'b0;
    tick();
    model_poll(0, 0);
  endtask

  task automatic read_bits(int first, int count, string ctx);
    for (int k = first; k < first + count; k++) begin
      expect_line(want[k], k + 1, tag_for(k, ctx));
      port_clk = 1'b0; tick();
      port_clk = 1'b1; tick();
      reads++;
    end
    if (first + count == 32) expect_line(1'b0, 33, {"R10/", ctx});
  endtask

  task automatic short_pulse();
    port_latch = 1'b1; port_clk = 1'b0;
    tick(); tick();
    port_clk = 1'b1;
    tick();
    port_latch = 1'b0;
    tick();
    if (armed && reads >= 16) begin
      shorts++;
      if (shorts == 31) begin
        mode = (mode + 1) % 3; shorts = 0; armed = 0;
      end
    end
  endtask

  task automatic burst(int n);
    repeat (n) short_pulse();
  endtask

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    tick();
    expect_line(1'b0, 0, "R1/R10 reset line");
    tick();

    poll();
    read_bits(0, 32, "R1 first poll");

    move(5, -3); move(10, 0);
    btn_left = 1'b1;
    poll();
    read_bits(0, 32, "R7 sum");

    btn_left = 1'b0; btn_right = 1'b1;
    poll_with_clock_inside();
    read_bits(0, 32, "R2 R9 hold");
    btn_right = 1'b0;

    repeat (3) move(100, -100);
    poll();
    read_bits(0, 32, "R8 sat");

    move(-7, 9);
    poll(20, -4);
    read_bits(0, 32, "R7 poll-cycle");
    poll();
    read_bits(0, 32, "R7 carry");

    poll();
    read_bits(0, 5, "R12 pre");
    move(4, 0);
    short_pulse();
    read_bits(5, 27, "R12 post");
    poll();
    read_bits(0, 32, "R12 kept");

    poll();
    read_bits(0, 10, "R11 unarmed");
    burst(31);
    read_bits(10, 22, "R11 unarmed");
    burst(30);
    poll();
    read_bits(0, 32, "R11 short burst");

    burst(31);
    poll();
    read_bits(0, 32, "R11 medium");
    burst(31);
    poll();
    read_bits(0, 32, "R11 high");
    burst(31);
    poll();
    read_bits(0, 32, "R11 wrap");

    tick(); tick();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule